// File: doc/BRIEF.md
# Programmable UDP Test Packet Generator

This block is a synthetic traffic source placed in front of a UDP transmit offload engine. It lets a receive path be benchmarked under worst-case load. Software writes four settings through a small write port while the generator is idle: the destination port, the payload length in bytes, the number of packets and the number of idle cycles between packets. A one-cycle start pulse then launches a run. During the run the block presents 64-bit payload beats with valid, last and byte-keep qualifiers. It holds each beat until the downstream ready accepts it. The block has no internal source of bubbles, so with a zero gap it fills the link completely.

Each payload word carries the packet sequence number in its upper half and the word index within the packet in its lower half. A receiver can therefore check ordering and spot lost words. The header is built downstream and is not part of this block. The block only supplies the port number, which stays constant for the whole run.

The sequencer has three states. IDLE waits for start. SEND presents beats. GAP counts out the inter-packet delay. The transitions are:
- IDLE to SEND: start with a non-zero count.
- IDLE to IDLE: start with a zero count, which sets done at once.
- SEND to SEND: within a packet, or when the gap is zero.
- SEND to GAP: on an accepted last beat when the gap is non-zero and packets remain.
- SEND to IDLE: on the accepted last beat of the final packet.
- GAP to SEND: when the delay counter reaches one.

Top module: `udp_test_gen`

## Requirements
- R1: After reset, busy, done and tx_valid are low. The settings reset to port 0, size 8, count 0 and gap 0.
- R2: A write while idle stores cfg_wdata into the setting selected by cfg_addr: 0 sets the port, 1 the payload size in bytes, 2 the packet count, 3 the gap in cycles.
- R3: After start with count N>0, exactly N packets are sent. Each packet has ceil(size/8) beats, with tx_last only on its final beat and no bubble inside a packet. A size of 0 is treated as 1 byte.
- R4: tx_data bits 63:32 hold the packet sequence number, counting from 0. Bits 31:0 hold the beat index within the packet, counting from 0.
- R5: tx_keep bit i qualifies tx_data byte i (bits 8i+7:8i). Every beat has keep 0xFF, except a last beat of a packet whose size is not a multiple of 8. That beat has only its low size-mod-8 bits set.
- R6: Between the accepted last beat of one packet and the first beat of the next, tx_valid is low for exactly gap cycles. A gap of 0 gives back-to-back packets.
- R7: While tx_valid is high and tx_ready is low, the beat (data, keep, last) is held unchanged in the next cycle.
- R8: busy is high from the cycle after an accepted start until the final beat is accepted. done rises in the cycle after the final beat and stays high until the next start.
- R9: A start with count 0 sets done in the next cycle, emits no beat and never raises busy.
- R10: Setting writes and start pulses made while busy are ignored. The run in progress and the stored settings are unchanged.
- R11: tx_port always equals the stored destination port setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 2 | Setting select |
| cfg_wdata | input | 32 | Setting write data |
| start | input | 1 | Run start pulse |
| tx_ready | input | 1 | Downstream accepts the current beat |
| tx_valid | output | 1 | Beat present |
| tx_data | output | 64 | Payload word |
| tx_keep | output | 8 | Byte qualifiers |
| tx_last | output | 1 | Final beat of packet |
| tx_port | output | 16 | Destination port for the offload engine |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed |

## Verification
The generator is run with sizes that fall on a word boundary (16), a short tail (20), a single byte and a zero size. This separates a wrong beat count from a wrong keep mask. Gaps of 0 and 3 show whether the delay is off by one or whether back-to-back packets gain a bubble. A run with a ready pattern that stalls every third cycle separates true holding of the beat from counters that advance without a handshake. A zero-count start and a run with writes poked mid-flight check the immediate completion and the frozen settings.

// File: rtl/udp_gen_pkg.sv
package udp_gen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_GAP  = 2'd2
    } gen_state_e;

    localparam logic [1:0] SEL_PORT  = 2'd0;
    localparam logic [1:0] SEL_SIZE  = 2'd1;
    localparam logic [1:0] SEL_COUNT = 2'd2;
    localparam logic [1:0] SEL_GAP   = 2'd3;
endpackage

// File: rtl/udp_gen_regs.sv
module udp_gen_regs
    import udp_gen_pkg::*;
#(
    parameter int PORT_W  = 16,
    parameter int CNT_W   = 16,
    parameter int WDATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [WDATA_W-1:0] cfg_wdata,
    input  logic               lock,
    output logic [PORT_W-1:0]  set_port,
    output logic [CNT_W-1:0]   set_size,
    output logic [CNT_W-1:0]   set_count,
    output logic [CNT_W-1:0]   set_gap
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_port  <= '0;
            set_size  <= CNT_W'(8);
            set_count <= '0;
            set_gap   <= '0;
        end else if (cfg_we && !lock) begin
            unique case (cfg_addr)
                SEL_PORT:  set_port  <= cfg_wdata[PORT_W-1:0];
                SEL_SIZE:  set_size  <= cfg_wdata[CNT_W-1:0];
                SEL_COUNT: set_count <= cfg_wdata[CNT_W-1:0];
                SEL_GAP:   set_gap   <= cfg_wdata[CNT_W-1:0];
                default:   ;
            endcase
        end
    end

    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(set_port) && $stable(set_size) && $stable(set_count) && $stable(set_gap)));
endmodule

// File: rtl/udp_gen_seq.sv
module udp_gen_seq
    import udp_gen_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int KEEP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tx_ready,
    input  logic [CNT_W-1:0] set_size,
    input  logic [CNT_W-1:0] set_count,
    input  logic [CNT_W-1:0] set_gap,
    output logic             tx_valid,
    output logic             tx_last,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] pkt_idx,
    output logic [CNT_W-1:0] beat_idx
);
    localparam int SH = $clog2(KEEP_W);

    gen_state_e state_q, state_d;
    logic [CNT_W-1:0] gap_q;
    logic [CNT_W-1:0] size_eff;
    logic [CNT_W:0]   size_round;
    logic [CNT_W-1:0] beats;
    logic             last_beat, final_pkt, accept;

    assign size_eff   = (set_size == '0) ? CNT_W'(1) : set_size;
    assign size_round = {1'b0, size_eff} + (CNT_W+1)'(KEEP_W - 1);
    assign beats      = CNT_W'(size_round >> SH);
    assign last_beat  = (beat_idx == beats - CNT_W'(1));
    assign final_pkt  = (pkt_idx == set_count - CNT_W'(1));
    assign accept     = (state_q == ST_SEND) && tx_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start && set_count != '0) state_d = ST_SEND;
            ST_SEND: if (tx_ready && last_beat) begin
                if (final_pkt)            state_d = ST_IDLE;
                else if (set_gap != '0)   state_d = ST_GAP;
                else                      state_d = ST_SEND;
            end
            ST_GAP:  if (gap_q == CNT_W'(1)) state_d = ST_SEND;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_idx <= '0;
            pkt_idx  <= '0;
            gap_q    <= '0;
            done     <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                beat_idx <= '0;
                pkt_idx  <= '0;
                done     <= (set_count == '0);
            end else if (accept) begin
                if (last_beat) begin
                    beat_idx <= '0;
                    pkt_idx  <= pkt_idx + CNT_W'(1);
                    gap_q    <= set_gap;
                    if (final_pkt) done <= 1'b1;
                end else begin
                    beat_idx <= beat_idx + CNT_W'(1);
                end
            end else if (state_q == ST_GAP) begin
                gap_q <= gap_q - CNT_W'(1);
            end
        end
    end

    always_comb begin
        tx_valid = (state_q == ST_SEND);
        tx_last  = tx_valid && last_beat;
        busy     = (state_q != ST_IDLE);
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(beat_idx) && $stable(pkt_idx) && $stable(tx_last)));
    assert_no_bubble_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !tx_last) |=> tx_valid);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy);
    assert_zero_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && set_count == '0) |=> (done && !busy && !tx_valid));
endmodule

// File: rtl/udp_gen_fmt.sv
module udp_gen_fmt #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 16
) (
    input  logic [CNT_W-1:0]    pkt_idx,
    input  logic [CNT_W-1:0]    beat_idx,
    input  logic                tx_last,
    input  logic [CNT_W-1:0]    set_size,
    output logic [DATA_W-1:0]   tx_data,
    output logic [DATA_W/8-1:0] tx_keep
);
    localparam int KEEP_W = DATA_W / 8;
    localparam int HALF_W = DATA_W / 2;
    localparam int SH     = $clog2(KEEP_W);

    logic [SH-1:0] tail;

    assign tail    = (set_size == '0) ? SH'(1) : set_size[SH-1:0];
    assign tx_data = {HALF_W'(pkt_idx), HALF_W'(beat_idx)};

    always_comb begin
        if (tx_last && tail != '0) tx_keep = ~({KEEP_W{1'b1}} << tail);
        else                       tx_keep = {KEEP_W{1'b1}};
    end
endmodule

// File: rtl/udp_test_gen.sv
module udp_test_gen #(
    parameter int DATA_W  = 64,
    parameter int PORT_W  = 16,
    parameter int CNT_W   = 16,
    parameter int WDATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_addr,
    input  logic [WDATA_W-1:0]  cfg_wdata,
    input  logic                start,
    input  logic                tx_ready,
    output logic                tx_valid,
    output logic [DATA_W-1:0]   tx_data,
    output logic [DATA_W/8-1:0] tx_keep,
    output logic                tx_last,
    output logic [PORT_W-1:0]   tx_port,
    output logic                busy,
    output logic                done
);
    localparam int KEEP_W = DATA_W / 8;

    logic [CNT_W-1:0] set_size, set_count, set_gap;
    logic [CNT_W-1:0] pkt_idx, beat_idx;

    udp_gen_regs #(.PORT_W(PORT_W), .CNT_W(CNT_W), .WDATA_W(WDATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .lock(busy), .set_port(tx_port),
        .set_size(set_size), .set_count(set_count), .set_gap(set_gap)
    );

    udp_gen_seq #(.CNT_W(CNT_W), .KEEP_W(KEEP_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_ready(tx_ready),
        .set_size(set_size), .set_count(set_count), .set_gap(set_gap),
        .tx_valid(tx_valid), .tx_last(tx_last), .busy(busy), .done(done),
        .pkt_idx(pkt_idx), .beat_idx(beat_idx)
    );

    udp_gen_fmt #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_fmt (
        .pkt_idx(pkt_idx), .beat_idx(beat_idx), .tx_last(tx_last),
        .set_size(set_size), .tx_data(tx_data), .tx_keep(tx_keep)
    );

    assert_keep_low_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> tx_keep[0]);
    assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> ($stable(tx_data) && $stable(tx_keep)));
endmodule

// File: tb/udp_test_gen_test.sv
module udp_test_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic        tx_ready = 1'b1;
    logic        tx_valid, tx_last, busy, done;
    logic [63:0] tx_data;
    logic [7:0]  tx_keep;
    logic [15:0] tx_port;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    udp_test_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start(start), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_keep(tx_keep),
        .tx_last(tx_last), .tx_port(tx_port), .busy(busy), .done(done)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_pkts(input string name, input int size, input int cnt, input int gap,
                            input logic [15:0] port, input bit stall, input bit poke);
        int eff, nb, rem, pk, bt, idle, cyc;
        bit after_last;
        logic [7:0] klast;
        wr(2'd0, 32'(port)); wr(2'd1, 32'(size)); wr(2'd2, 32'(cnt)); wr(2'd3, 32'(gap));
        eff = (size == 0) ? 1 : size;
        nb = (eff + 7) / 8;
        rem = eff % 8;
        klast = (rem == 0) ? 8'hFF : 8'((1 << rem) - 1);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk({name, " R8 busy after start"}, 64'(busy), 64'd1);
        chk({name, " R8 done cleared by start"}, 64'(done), 64'd0);
        pk = 0; bt = 0; idle = 0; cyc = 0; after_last = 1'b0;
        while (pk < cnt && cyc < 20000) begin
            tx_ready = stall ? (cyc % 3 != 2) : 1'b1;
            if (poke) begin
                if (cyc == 2) begin cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'hBEEF; start = 1'b1; end
                if (cyc == 3) begin cfg_addr = 2'd2; cfg_wdata = 32'd1; end
                if (cyc == 4) begin cfg_we = 1'b0; start = 1'b0; end
            end
            if (tx_valid) begin
                if (after_last) begin
                    chk({name, " R6 idle cycles between packets"}, 64'(idle), 64'(gap));
                    after_last = 1'b0;
                end
                if (tx_ready) begin
                    chk({name, " R4 payload word"}, tx_data, {32'(pk), 32'(bt)});
                    chk({name, " R3 last flag"}, 64'(tx_last), 64'(bt == nb - 1));
                    chk({name, " R5 keep"}, 64'(tx_keep), (bt == nb - 1) ? 64'(klast) : 64'hFF);
                    chk({name, " R11 port"}, 64'(tx_port), 64'(port));
                    if (bt == nb - 1) begin
                        bt = 0; pk++; after_last = 1'b1; idle = 0;
                    end else begin
                        bt++;
                    end
                end
            end else if (after_last) begin
                idle++;
            end else begin
                chk({name, " R3 bubble inside packet"}, 64'(tx_valid), 64'd1);
            end
            cyc++;
            @(negedge clk);
        end
        tx_ready = 1'b1;
        chk({name, " R3 packets sent"}, 64'(pk), 64'(cnt));
        chk({name, " R8 done after final beat"}, 64'(done), 64'd1);
        chk({name, " R8 busy low after final beat"}, 64'(busy), 64'd0);
        chk({name, " R3 no extra beat"}, 64'(tx_valid), 64'd0);
        if (poke) chk({name, " R10 port kept after run"}, 64'(tx_port), 64'(port));
    endtask

    task automatic t_reset;
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 valid", 64'(tx_valid), 64'd0);
        chk("R1 port", 64'(tx_port), 64'd0);
        chk("R1 keep with default size", 64'(tx_keep), 64'hFF);
    endtask

    task automatic t_zero_count;
        bit saw = 1'b0;
        wr(2'd2, 32'd0);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R9 done next cycle", 64'(done), 64'd1);
        for (int i = 0; i < 4; i++) begin
            if (busy || tx_valid) saw = 1'b1;
            @(negedge clk);
        end
        chk("R9 no busy and no beat", 64'(saw), 64'd0);
        chk("R8 done stays high", 64'(done), 64'd1);
    endtask

    task automatic t_write_port;
        wr(2'd0, 32'h0000_5A5A);
        chk("R2 port write while idle", 64'(tx_port), 64'h5A5A);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_write_port();
        run_pkts("tail20_gap0", 20, 2, 0, 16'h1234, 1'b0, 1'b0);
        run_pkts("size16_gap3", 16, 3, 3, 16'h4321, 1'b0, 1'b0);
        run_pkts("size1_gap1", 1, 2, 1, 16'h0101, 1'b0, 1'b0);
        run_pkts("size0", 0, 1, 0, 16'h0F0F, 1'b0, 1'b0);
        run_pkts("stall_tail29", 29, 3, 2, 16'hA0A0, 1'b1, 1'b0);
        run_pkts("poke_R10", 24, 3, 0, 16'h7777, 1'b0, 1'b1);
        t_zero_count();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule